// File: doc/BRIEF.md
# System-Control Status/Cause Write Unit

This block holds the processor's two system-control registers, the Status word and the Cause word. It applies software writes to them through per-bit write masks. A single-cycle write strobe, a register select and a 32-bit data word arrive from the instruction pipeline. Configuration inputs say which architecture release is active (release 2, release 6), which Status bits the core implements as writable, and whether a supervisor privilege level exists.

The masks depend on the release. Some Status and Cause bits may only be cleared by software. A parameter enables a 64-bit variant in which the three address-segment enable bits form a chain. Each write also has side effects. A change of the count-disable bit stops or restarts the count timer. A change of either software-interrupt pending bit updates the matching request line. Clearing any segment enable that was set sends a one-cycle flush pulse to the address-translation cache. Every output is registered, and each effect becomes visible in the cycle after the write edge.

Top module: `sysctl_wr_unit`

## Requirements
- R1: After reset, Status reads 0x00400004 (bit 22 boot-vector select and bit 2 error level set), Cause reads 0, and count_halt, sw_irq and xlat_flush are all 0.
- R2: A Cause write changes only bits 8, 9, 22 and 23, which take the write data. Every other Cause bit keeps its value.
- R3: When cfg_r2 is 1, Cause bit 27 (count disable) is also writable. When cfg_r2 is 0, it keeps its value.
- R4: When cfg_r6 is 1, a write can clear Cause bit 22 (watch pending), but writing 1 to it leaves the bit unchanged.
- R5: count_halt always equals Cause bit 27. It goes to 1 (timer stopped) when a write sets the bit and back to 0 (timer running) when a write clears it.
- R6: sw_irq[i] (i = 0, 1) follows Cause bit 8+i and takes the new value in the cycle after the write that changed it.
- R7: A Status write sets Status to (old AND NOT cfg_status_mask) OR (data AND cfg_status_mask). When cfg_r6 is 0, the data is used unmodified.
- R8: When cfg_r6 and cfg_sup are both 1, a Status write whose bits 4:3 (privilege field) equal 3 leaves that field unchanged. The rest of the word is written normally.
- R9: When cfg_r6 is 1, Status bits 20 (soft reset) and 19 (non-maskable interrupt) can only be cleared. A written 1 leaves the bit unchanged.
- R10: With SEG64 = 1 and cfg_r6 = 1, the written bit 6 (supervisor segment) is forced to 0 unless bit 7 (kernel segment) is 1. Bit 5 (user segment) is forced to 0 unless the resulting bit 6 is 1.
- R11: With SEG64 = 1, xlat_flush is 1 for exactly the cycle after a Status write that clears any of bits 7:5 that were 1 before the write.
- R12: wr_sel = 0 selects Status and wr_sel = 1 selects Cause. The unselected register does not change. Without wr_en, neither register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_sel | input | 1 | 0 = Status, 1 = Cause |
| wr_data | input | 32 | Write data |
| cfg_r2 | input | 1 | Release-2 features present |
| cfg_r6 | input | 1 | Release-6 rules active |
| cfg_status_mask | input | 32 | Writable-bit mask for Status |
| cfg_sup | input | 1 | Supervisor privilege level implemented |
| status_q | output | 32 | Current Status value |
| cause_q | output | 32 | Current Cause value |
| count_halt | output | 1 | 1 = count timer stopped |
| sw_irq | output | 2 | Software-interrupt request lines |
| xlat_flush | output | 1 | One-cycle translation flush pulse |

## Verification
Cause is first written with all ones and then with zeros under each release setting. This shows the fixed mask, the count-disable bit that appears only with release 2, and the watch bit that can only be cleared under release 6. Status writes are tried with a partial mask outside release 6, which exposes the plain merge and the absence of segment chaining. They are then tried under release 6 with segment patterns that break the chain at each link, privilege-field values of 1 and 3 with and without a supervisor level, and soft-reset/NMI patterns that try to set and then clear each bit. Flush checks pair a write that clears a set segment bit with one that only sets bits. Each flush check also looks at the following cycle, which shows whether the pulse lasts exactly one cycle.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
   localparam int REG_W = 32;

   // Status bit positions (decoded by neighbouring logic)
   localparam int ST_KX   = 7;
   localparam int ST_SX   = 6;
   localparam int ST_UX   = 5;
   localparam int ST_PRV  = 3;   // 2-bit privilege field at 4:3
   localparam int ST_SRST = 20;
   localparam int ST_NMI  = 19;
   localparam int ST_BOOT = 22;
   localparam int ST_ERRL = 2;

   // Cause bit positions
   localparam int CA_DC   = 27;
   localparam int CA_WP   = 22;
   localparam int CA_SWI  = 8;

   localparam logic [REG_W-1:0] CAUSE_BASE_MASK = 32'h00C0_0300;
   localparam logic [REG_W-1:0] STATUS_RST =
      (32'd1 << ST_BOOT) | (32'd1 << ST_ERRL);
   localparam logic [REG_W-1:0] SEG_BITS =
      (32'd1 << ST_KX) | (32'd1 << ST_SX) | (32'd1 << ST_UX);

   function automatic logic [REG_W-1:0] merge_masked(
      input logic [REG_W-1:0] old_v,
      input logic [REG_W-1:0] new_v,
      input logic [REG_W-1:0] msk);
      merge_masked = (old_v & ~msk) | (new_v & msk);
   endfunction
endpackage

// File: rtl/sysctl_status_reg.sv
module sysctl_status_reg
   import sysctl_pkg::*;
#(
   parameter bit SEG64 = 1'b1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [REG_W-1:0] data,
   input  logic             r6,
   input  logic             sup,
   input  logic [REG_W-1:0] rw_mask,
   output logic [REG_W-1:0] q,
   output logic             flush
);
   logic [REG_W-1:0] data_adj;
   logic [REG_W-1:0] eff_mask;
   logic [REG_W-1:0] nxt;
   logic             flush_nxt;

   generate
      if (SEG64) begin : g_seg_chain
         logic kx_w, sx_w, ux_w;
         always_comb begin
            kx_w = data[ST_KX];
            sx_w = data[ST_SX] & kx_w;
            ux_w = data[ST_UX] & sx_w;
            data_adj = data;
            if (r6) begin
               data_adj[ST_SX] = sx_w;
               data_adj[ST_UX] = ux_w;
            end
         end
         assign flush_nxt = we && ((q & ~nxt & SEG_BITS) != '0);
      end else begin : g_seg_flat
         assign data_adj  = data;
         assign flush_nxt = 1'b0;
      end
   endgenerate

   always_comb begin
      eff_mask = rw_mask;
      if (r6) begin
         if (sup && (data_adj[ST_PRV +: 2] == 2'b11))
            eff_mask[ST_PRV +: 2] = 2'b00;
         if (data_adj[ST_SRST]) eff_mask[ST_SRST] = 1'b0;
         if (data_adj[ST_NMI])  eff_mask[ST_NMI]  = 1'b0;
      end
      nxt = merge_masked(q, data_adj, eff_mask);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q     <= STATUS_RST;
         flush <= 1'b0;
      end else begin
         if (we) q <= nxt;
         flush <= flush_nxt;
      end
   end
endmodule

// File: rtl/sysctl_cause_reg.sv
module sysctl_cause_reg
   import sysctl_pkg::*;
#(
   parameter int SWI_N = 2
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [REG_W-1:0] data,
   input  logic             r2,
   input  logic             r6,
   output logic [REG_W-1:0] q,
   output logic             halt,
   output logic [SWI_N-1:0] swi
);
   logic [REG_W-1:0] eff_mask;
   logic [REG_W-1:0] nxt;

   always_comb begin
      eff_mask = CAUSE_BASE_MASK;
      if (r2) eff_mask[CA_DC] = 1'b1;
      if (r6 && data[CA_WP]) eff_mask[CA_WP] = 1'b0;
      nxt = merge_masked(q, data, eff_mask);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q    <= '0;
         halt <= 1'b0;
      end else if (we) begin
         q <= nxt;
         if (nxt[CA_DC] != q[CA_DC]) halt <= nxt[CA_DC];
      end
   end

   for (genvar i = 0; i < SWI_N; i++) begin : g_swi
      always_ff @(posedge clk) begin
         if (!rst_n)
            swi[i] <= 1'b0;
         else if (we && (nxt[CA_SWI+i] != q[CA_SWI+i]))
            swi[i] <= nxt[CA_SWI+i];
      end
   end
endmodule

// File: rtl/sysctl_wr_unit.sv
module sysctl_wr_unit
   import sysctl_pkg::*;
#(
   parameter bit SEG64 = 1'b1,
   parameter int SWI_N = 2
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic        wr_sel,
   input  logic [31:0] wr_data,
   input  logic        cfg_r2,
   input  logic        cfg_r6,
   input  logic [31:0] cfg_status_mask,
   input  logic        cfg_sup,
   output logic [31:0] status_q,
   output logic [31:0] cause_q,
   output logic        count_halt,
   output logic [1:0]  sw_irq,
   output logic        xlat_flush
);
   localparam int SEL_STATUS = 0;
   localparam int SEL_CAUSE  = 1;

   generate
      if (SWI_N != 2) begin : g_bad_swi
         $error("sysctl_wr_unit: SWI_N must be 2");
      end
   endgenerate

   logic we_status, we_cause;
   assign we_status = wr_en && (wr_sel == 1'(SEL_STATUS));
   assign we_cause  = wr_en && (wr_sel == 1'(SEL_CAUSE));

   sysctl_status_reg #(.SEG64(SEG64)) u_status (
      .clk(clk), .rst_n(rst_n), .we(we_status), .data(wr_data),
      .r6(cfg_r6), .sup(cfg_sup), .rw_mask(cfg_status_mask),
      .q(status_q), .flush(xlat_flush)
   );

   sysctl_cause_reg #(.SWI_N(SWI_N)) u_cause (
      .clk(clk), .rst_n(rst_n), .we(we_cause), .data(wr_data),
      .r2(cfg_r2), .r6(cfg_r6),
      .q(cause_q), .halt(count_halt), .swi(sw_irq)
   );
endmodule

// File: rtl/sysctl_wr_unit_chk.sv
module sysctl_wr_unit_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        wr_en,
   input logic        wr_sel,
   input logic [31:0] wr_data,
   input logic        cfg_r6,
   input logic        cfg_sup,
   input logic [31:0] status_q,
   input logic [31:0] cause_q,
   input logic        count_halt,
   input logic [1:0]  sw_irq,
   input logic        xlat_flush
);
   // R2 / R3: only the writable Cause positions can ever be nonzero
   p_cause_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cause_q & ~32'h08C0_0300) == 32'h0);

   // R5
   p_halt_follows_dc_r5: assert property (@(posedge clk) disable iff (!rst_n)
      count_halt == cause_q[27]);

   // R6
   p_swi_follows_ip_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sw_irq == cause_q[9:8]);

   // R8
   p_prv_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_sel && cfg_r6 && cfg_sup && wr_data[4:3] == 2'b11)
      |=> $stable(status_q[4:3]));

   // R9
   p_srst_clear_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_r6 && !status_q[20]) |=> !status_q[20]);

   // R11
   p_flush_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
      xlat_flush |-> (($past(status_q) & ~status_q & 32'h0000_00E0) != 32'h0));

   // R12
   p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(status_q) && $stable(cause_q)));
endmodule

bind sysctl_wr_unit sysctl_wr_unit_chk u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
   .wr_data(wr_data), .cfg_r6(cfg_r6), .cfg_sup(cfg_sup),
   .status_q(status_q), .cause_q(cause_q), .count_halt(count_halt),
   .sw_irq(sw_irq), .xlat_flush(xlat_flush)
);

// File: tb/sysctl_wr_unit_bench.sv
module sysctl_wr_unit_bench;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG_CYC = 5000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_sel = 1'b0;
   logic [31:0] wr_data = '0;
   logic        cfg_r2 = 1'b0;
   logic        cfg_r6 = 1'b0;
   logic [31:0] cfg_status_mask = 32'hFFFF_FFFF;
   logic        cfg_sup = 1'b0;
   logic [31:0] status_q, cause_q;
   logic        count_halt, xlat_flush;
   logic [1:0]  sw_irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sysctl_wr_unit u_sysctl_wr_unit (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .cfg_r2(cfg_r2), .cfg_r6(cfg_r6),
      .cfg_status_mask(cfg_status_mask), .cfg_sup(cfg_sup),
      .status_q(status_q), .cause_q(cause_q), .count_halt(count_halt),
      .sw_irq(sw_irq), .xlat_flush(xlat_flush)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   // one write; returns at the negedge after the capturing edge
   task automatic wr(input logic sel, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle();
      @(negedge clk);
   endtask

   task automatic t_reset();
      check("R1 status", status_q, 32'h0040_0004);
      check("R1 cause", cause_q, 32'h0);
      check("R1 halt/irq/flush", {29'd0, count_halt, sw_irq}, 32'h0);
      check("R1 flush", {31'd0, xlat_flush}, 32'h0);
   endtask

   task automatic t_cause_mask();
      cfg_r2 = 1'b0; cfg_r6 = 1'b0;
      wr(1'b1, 32'hFFFF_FFFF);
      check("R2 cause all-ones", cause_q, 32'h00C0_0300);
      check("R3 dc locked without r2", {31'd0, count_halt}, 32'h0);
      check("R6 both irq", {30'd0, sw_irq}, 32'h3);
      check("R12 status untouched", status_q, 32'h0040_0004);
      wr(1'b1, 32'h0000_0100);
      check("R2 cause partial", cause_q, 32'h0000_0100);
      check("R6 irq0 only", {30'd0, sw_irq}, 32'h1);
      wr(1'b1, 32'h0);
      check("R6 irq cleared", {30'd0, sw_irq}, 32'h0);
   endtask

   task automatic t_dc();
      cfg_r2 = 1'b1;
      wr(1'b1, 32'h0800_0000);
      check("R3 dc written", cause_q, 32'h0800_0000);
      check("R5 timer halted", {31'd0, count_halt}, 32'h1);
      wr(1'b1, 32'h0000_0200);
      check("R5 timer restarted", {31'd0, count_halt}, 32'h0);
      check("R6 irq1 only", {30'd0, sw_irq}, 32'h2);
      wr(1'b1, 32'h0);
   endtask

   task automatic t_wp();
      cfg_r6 = 1'b0;
      wr(1'b1, 32'h0040_0000);
      check("R2 wp set pre-r6", cause_q, 32'h0040_0000);
      cfg_r6 = 1'b1;
      wr(1'b1, 32'h0000_0000);
      check("R4 wp cleared", cause_q, 32'h0);
      wr(1'b1, 32'h0040_0000);
      check("R4 wp set ignored", cause_q, 32'h0);
      cfg_r6 = 1'b0;
   endtask

   task automatic t_status_merge();
      cfg_r6 = 1'b0; cfg_status_mask = 32'h0000_FFFF;
      wr(1'b0, 32'hFFFF_FFFF);
      check("R7 masked merge", status_q, 32'h0040_FFFF);
      check("R11 no flush on set", {31'd0, xlat_flush}, 32'h0);
      check("R12 cause untouched", cause_q, 32'h0);
      wr(1'b0, 32'h0);
      check("R7 masked clear", status_q, 32'h0040_0000);
      check("R11 flush pulse", {31'd0, xlat_flush}, 32'h1);
      idle();
      check("R11 flush one cycle", {31'd0, xlat_flush}, 32'h0);
      check("R12 idle hold", status_q, 32'h0040_0000);
      wr(1'b0, 32'h0000_0020);
      check("R7 no chain pre-r6", status_q, 32'h0040_0020);
      cfg_status_mask = 32'hFFFF_FFFF;
      wr(1'b0, 32'h0);
   endtask

   task automatic t_seg_chain();
      cfg_r6 = 1'b1; cfg_sup = 1'b0;
      wr(1'b0, 32'h0000_00E0);
      check("R10 full chain", status_q, 32'h0000_00E0);
      wr(1'b0, 32'h0000_0060);
      check("R10 no kx kills sx,ux", status_q, 32'h0);
      check("R11 flush after chain clear", {31'd0, xlat_flush}, 32'h1);
      wr(1'b0, 32'h0000_00A0);
      check("R10 no sx kills ux", status_q, 32'h0000_0080);
      check("R11 no flush", {31'd0, xlat_flush}, 32'h0);
      wr(1'b0, 32'h0);
   endtask

   task automatic t_prv();
      cfg_r6 = 1'b1; cfg_sup = 1'b1;
      wr(1'b0, 32'h0000_0008);
      check("R8 prv=1 written", status_q, 32'h0000_0008);
      wr(1'b0, 32'h0000_0018);
      check("R8 prv=3 ignored", status_q, 32'h0000_0008);
      cfg_sup = 1'b0;
      wr(1'b0, 32'h0000_0018);
      check("R8 prv=3 without sup", status_q, 32'h0000_0018);
      wr(1'b0, 32'h0);
   endtask

   task automatic t_srnmi();
      cfg_r6 = 1'b0;
      wr(1'b0, 32'h0018_0000);
      check("R7 sr/nmi set pre-r6", status_q, 32'h0018_0000);
      cfg_r6 = 1'b1;
      wr(1'b0, 32'h0008_0000);
      check("R9 sr clear, nmi kept", status_q, 32'h0008_0000);
      wr(1'b0, 32'h0);
      check("R9 nmi cleared", status_q, 32'h0);
      wr(1'b0, 32'h0018_0000);
      check("R9 set ignored", status_q, 32'h0);
   endtask

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_cause_mask();
      t_dc();
      t_wp();
      t_status_merge();
      t_seg_chain();
      t_prv();
      t_srnmi();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : watchdog
      repeat (WATCHDOG_CYC) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule